// File: doc/BRIEF.md
# Input change-of-state detector

This block watches a small group of asynchronous input pins and flags each one that changes level. Every pin passes through a two-flop synchronizer. A sample tick then filters it, so a new level is accepted only after it has been seen on two ticks in a row. An accepted change sets a sticky per-pin flag.

The flags and the synchronized live levels are presented together as one register word. Reading that word clears every flag. A single interrupt status bit collects change events from the pins whose enable-mask bit is on. The same read also clears this bit.

A host reads the word when the interrupt bit is high, or when it polls. The live-level half of the word tells the host the present state of every pin.

Top module: `icd_top`

## Requirements
- R1: `stat_o[NPINS-1:0]` holds the pin levels after a two-flop synchronizer. A pin change appears there on the second rising clock edge after it. Bit i belongs to pin i.
- R2: `stat_o[NPINS+i]` is pin i's change flag. A sample tick occurs once every TICK_DIV clocks. The first tick is the (TICK_DIV)th clock edge after reset is released. The flag sets on a tick when the synchronized level differs from the accepted level and equals the level taken on the previous tick. A level held for less than TICK_DIV clocks sets no flag.
- R3: While `rd_i` is high on a clock edge, all change flags clear at that edge.
- R4: When a change is accepted on the same edge as a read, that pin's flag is set, not cleared.
- R5: `irq_o` sets on the edge where a change is accepted on a pin whose `en_i` bit is 1.
- R6: An accepted change on a pin whose `en_i` bit is 0 still sets its flag. It leaves `irq_o` unchanged.
- R7: A read clears `irq_o` unless an enabled change is accepted on the same edge.
- R8: Synchronous active-high reset clears all flags and `irq_o`. It loads the accepted and sampled levels from the current pins, so the levels present at reset report no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous monitored pins |
| rd_i | input | 1 | Register read strobe, one clock per read |
| en_i | input | NPINS | Per-pin interrupt enable mask |
| stat_o | output | 2*NPINS | Change flags (upper half) and live levels (lower half) |
| irq_o | output | 1 | Combined input-change interrupt status |

## Verification
The bench builds the block with NPINS=4 and TICK_DIV=3. With a divider above one, a pulse can be shorter than a tick period and must be filtered out, and tick edges fall at varied cycles relative to reads. Random pin holds of one to twelve clocks mix filtered glitches with accepted changes. Random reads and mask values then make reads coincide with accepted changes, on both enabled and disabled pins.

// File: rtl/icd_pkg.sv
package icd_pkg;
  function automatic int cnt_width(input int div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction
endpackage

// File: rtl/icd_sync.sv
module icd_sync #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] lvl_o
);
  logic [NPINS-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= pin_i;
      lvl_o  <= pin_i;
    end else begin
      meta_q <= pin_i;
      lvl_o  <= meta_q;
    end
  end
endmodule

// File: rtl/icd_tick.sv
module icd_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  import icd_pkg::*;
  localparam int CW = cnt_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/icd_filter.sv
module icd_filter (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic lvl_i,
  input  logic tick_i,
  output logic evt_o
);
  logic acc_q;
  logic prev_q;

  assign evt_o = tick_i && (lvl_i != acc_q) && (lvl_i == prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= raw_i;
      prev_q <= raw_i;
    end else if (tick_i) begin
      prev_q <= lvl_i;
      if (evt_o) acc_q <= lvl_i;
    end
  end
endmodule

// File: rtl/icd_top.sv
module icd_top #(
  parameter int NPINS    = 4,
  parameter int TICK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pin_i,
  input  logic               rd_i,
  input  logic [NPINS-1:0]   en_i,
  output logic [2*NPINS-1:0] stat_o,
  output logic               irq_o
);
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] flag_q;
  logic             tick;

  icd_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .lvl_o(lvl)
  );

  icd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    icd_filter u_filt (
      .clk(clk), .rst(rst), .raw_i(pin_i[g]), .lvl_i(lvl[g]),
      .tick_i(tick), .evt_o(evt[g])
    );

    always_ff @(posedge clk) begin
      if (rst)         flag_q[g] <= 1'b0;
      else if (evt[g]) flag_q[g] <= 1'b1;
      else if (rd_i)   flag_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                irq_o <= 1'b0;
    else if (|(evt & en_i)) irq_o <= 1'b1;
    else if (rd_i)          irq_o <= 1'b0;
  end

  assign stat_o = {flag_q, lvl};
endmodule

// File: rtl/icd_chk.sv
module icd_chk #(
  parameter int NPINS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_i,
  input logic [NPINS-1:0]   en_i,
  input logic [NPINS-1:0]   evt,
  input logic [2*NPINS-1:0] stat_o,
  input logic               irq_o
);
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat_o[2*NPINS-1:NPINS] & $past(evt)) == $past(evt)));
  p_rd_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !(|evt)) |=> (stat_o[2*NPINS-1:NPINS] == '0));
  p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
    (|(evt & en_i)) |=> irq_o);
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (!(|(evt & en_i)) && !irq_o) |=> !irq_o);
  p_rd_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !(|(evt & en_i))) |=> !irq_o);
endmodule

bind icd_top icd_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .rd_i(rd_i), .en_i(en_i), .evt(evt),
  .stat_o(stat_o), .irq_o(irq_o)
);

// File: tb/icd_top_tb.sv
module icd_top_tb_top;
  localparam int NP  = 4;
  localparam int DIV = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin = 4'b1010;
  logic          rd  = 1'b0;
  logic [NP-1:0] en  = '0;
  logic [2*NP-1:0] stat;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  icd_top #(.NPINS(NP), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .rd_i(rd), .en_i(en),
    .stat_o(stat), .irq_o(irq)
  );

  always #4 clk = ~clk;

  // reference model built from R1..R8
  logic [NP-1:0] m_s1, m_s2, m_acc, m_prev, m_flag;
  logic          m_irq;
  int            m_cnt;
  bit            m_race;

  function automatic logic [NP-1:0] accept(input logic tk, input logic [NP-1:0] s2,
                                           input logic [NP-1:0] acc, input logic [NP-1:0] pv);
    return tk ? ((s2 ^ acc) & ~(s2 ^ pv)) : '0;
  endfunction

  always @(posedge clk) begin
    logic tk;
    logic [NP-1:0] ev;
    if (rst) begin
      m_s1 = pin; m_s2 = pin; m_acc = pin; m_prev = pin;
      m_flag = '0; m_irq = 1'b0; m_cnt = 0; m_race = 1'b0;
    end else begin
      tk = (m_cnt == DIV - 1);
      ev = accept(tk, m_s2, m_acc, m_prev);
      m_race = rd && (ev != '0);
      if (tk) begin
        m_prev = m_s2;
        m_acc  = m_acc ^ ev;
      end
      m_cnt  = tk ? 0 : m_cnt + 1;
      m_flag = ev | (rd ? '0 : m_flag);
      m_irq  = (|(ev & en)) ? 1'b1 : (rd ? 1'b0 : m_irq);
      m_s2   = m_s1;
      m_s1   = pin;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    check("R1", 8'(stat[NP-1:0]), 8'(m_s2));
    check(rd ? "R3" : "R2", 8'(stat[2*NP-1:NP]), 8'(m_flag));
    check(en == '1 ? "R5" : "R6", 8'(irq), 8'(m_irq));
    if (m_race) check("R4", 8'(stat[2*NP-1:NP]), 8'(m_flag));
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int seed;
    int hold;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8", 8'(stat[2*NP-1:NP]), 8'h0);
    check("R8", 8'(irq), 8'h0);
    check("R1", 8'(stat[NP-1:0]), 8'ha);
    step(10);
    check("R8", 8'(stat[2*NP-1:NP]), 8'h0);

    // glitch shorter than a tick period: no flag (R2)
    pin[0] = 1'b1;
    @(negedge clk); pin[0] = 1'b0;
    step(12);
    check("R2", 8'(stat[2*NP-1:NP]), 8'h0);

    // disabled pin: flag set, no interrupt (R6)
    en = 4'b1110;
    pin[0] = 1'b1;
    step(14);
    check("R6", 8'(stat[NP]), 8'h1);
    check("R6", 8'(irq), 8'h0);

    // read clears flags (R3)
    rd = 1'b1;
    @(negedge clk); cmp_model(); rd = 1'b0;
    check("R3", 8'(stat[2*NP-1:NP]), 8'h0);

    // enabled pin raises interrupt (R5), read clears it (R7)
    pin[3] = 1'b0;
    step(14);
    check("R5", 8'(irq), 8'h1);
    check("R5", 8'(stat[2*NP-1]), 8'h1);
    rd = 1'b1;
    @(negedge clk); cmp_model(); rd = 1'b0;
    check("R7", 8'(irq), 8'h0);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      if ($urandom_range(0, 9) == 0) pin[$urandom_range(0, NP-1)] ^= 1'b1;
      if ($urandom_range(0, 63) == 0) en = NP'($urandom);
      rd = ($urandom_range(0, 5) == 0);
      hold = $urandom_range(1, 12);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        cmp_model();
        rd = 1'b0;
      end
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule